// File: doc/BRIEF.md
# Keyed Serial Register Access Engine

This block sits next to a byte-wide static memory and watches every bus cycle that reaches it. Software opens a back door to eight timekeeping registers by writing a fixed 64-bit key. Each key bit rides on data line 0 of one write cycle, and the address does not matter. Until the key has matched completely, every cycle is granted to the memory, including the key writes. Once the key matches, the next 64 bus cycles do not go to memory. Instead, each cycle moves one bit of the timekeeping registers over data line 0. A read cycle shifts a bit out and a write cycle shifts a bit in.

Bus cycles are presented as single-clock strobes, each carrying a direction and the value on data line 0. The register contents are sampled once, at the moment of unlock, so a full read-out is coherent. Written bits are gathered per register and committed as whole bytes. An external reset pin, unless the register file's reset-ignore bit is set, aborts a transfer with no commit.

Top module: `keyed_serial_port`

## Requirements
- R1: After reset, no register commit is signalled, no serial output is driven, and every valid cycle is granted to memory.
- R2: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, each sent least significant bit first, one bit per write cycle on data line 0. When the 64th bit matches, the block enters transfer mode starting with the next valid cycle.
- R3: Outside transfer mode, every valid cycle, including key writes, is granted to memory and no serial output is driven.
- R4: A write whose data bit differs from the expected key bit freezes recognition. Further writes are ignored until a read cycle rearms it.
- R5: Any read cycle outside transfer mode returns recognition to key bit 0, whatever the progress so far.
- R6: The 64-bit register image is captured on the clock edge that completes the key. Serial reads return bits of that captured image, not the live input.
- R7: Transfer cycle k (0 to 63) carries bit k mod 8 of register k/8. After 64 transfer cycles the block returns to memory mode and needs a fresh key.
- R8: The cycle after a write that carries bit 7 of register r, tkWrEn has exactly bit r set. tkWrData then holds that register's eight bits. Bits that arrived by writes in that byte take the written value, and bits that arrived by reads take the captured value. A register whose bit-7 cycle is a read is not committed.
- R9: No valid cycle is granted to memory during transfer mode, and serial output is driven only on transfer-mode reads.
- R10: While rstIgnore is 0, rstPinN low during transfer mode aborts at once. That cycle shifts nothing, commits nothing and drives nothing, and the block is back in memory mode with recognition at bit 0 from the next cycle.
- R11: While rstIgnore is 1, rstPinN has no effect on a transfer.
- R12: Clock cycles with cycValid low change neither recognition progress nor transfer progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycValid | input | 1 | A bus cycle is present this clock |
| cycWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| cycDq0 | input | 1 | Data line 0 value of a write cycle |
| rstPinN | input | 1 | External abort pin, active low |
| rstIgnore | input | 1 | Register-file bit: 1 makes rstPinN ineffective |
| tkSnap | input | 64 | Live timekeeping register image, register r in bits 8r+7..8r |
| memGrant | output | 1 | This cycle may access the memory |
| dqOut | output | 1 | Serial output bit for a transfer read |
| dqOutEn | output | 1 | Drive dqOut onto data line 0 this cycle |
| tkWrEn | output | 8 | One-hot register commit strobe |
| tkWrData | output | 8 | Byte committed with tkWrEn |

## Verification
The outputs memGrant, dqOut and dqOutEn are combinational on the current cycle's inputs and registered state, so they are due in the same clock as the cycle. The bench samples them one nanosecond after it drives a cycle on the falling edge. A register commit comes out of a register one clock later. The bench therefore checks tkWrEn and tkWrData one nanosecond after the rising edge that closes the cycle carrying bit 7. A reference model in the bench updates its expected pointer, mode, captured image and byte buffer only after each cycle's checks, matching the edge at which the design changes state.

// File: rtl/ksp_pkg.sv
package ksp_pkg;
  localparam int N_REG     = 8;
  localparam int REG_W     = 8;
  localparam int XFER_BITS = N_REG * REG_W;
  localparam int XFER_IDX  = $clog2(XFER_BITS);
  localparam int KEY_BITS  = 64;
  // byte 0 occupies the least significant bits; bit 0 is sent first
  localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  typedef struct packed {
    logic                loadSnap;
    logic                shiftRd;
    logic                shiftWr;
    logic                commit;
    logic [XFER_IDX-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/ksp_ctrl.sv
module ksp_ctrl
  import ksp_pkg::*;
#(
  parameter int                  KEYW  = KEY_BITS,
  parameter logic [KEYW-1:0]     KEY   = UNLOCK_KEY,
  parameter int                  NREG  = N_REG,
  parameter int                  REGW  = REG_W,
  localparam int                 XB    = NREG * REGW,
  localparam int                 XIDX  = $clog2(XB),
  localparam int                 BW    = $clog2(REGW),
  localparam int                 KPW   = $clog2(KEYW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cycValid,
  input  logic           cycWrite,
  input  logic           cycDq0,
  input  logic           abortReq,
  output strobe_t        stb,
  output logic           inXfer,
  output logic [KPW-1:0] keyPtr,
  output logic           keyBlocked,
  output logic           memGrant,
  output logic           dqOutEn
);
  logic [XIDX-1:0] bitCnt;
  logic            abortNow;
  logic            liveCyc;
  logic            keyHit;
  logic            keyLast;
  logic            xferLast;

  always_comb begin
    abortNow = inXfer && abortReq;
    liveCyc  = cycValid && inXfer && !abortNow;
    keyHit   = cycValid && cycWrite && !inXfer && !keyBlocked &&
               (cycDq0 == KEY[keyPtr]);
    keyLast  = (keyPtr == KPW'(KEYW - 1));
    xferLast = (bitCnt == XIDX'(XB - 1));

    stb.loadSnap = keyHit && keyLast;
    stb.shiftRd  = liveCyc && !cycWrite;
    stb.shiftWr  = liveCyc && cycWrite;
    stb.commit   = liveCyc && cycWrite && (bitCnt[BW-1:0] == BW'(REGW - 1));
    stb.bitIdx   = bitCnt;

    memGrant = cycValid && !inXfer;
    dqOutEn  = stb.shiftRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inXfer     <= 1'b0;
      keyPtr     <= '0;
      keyBlocked <= 1'b0;
      bitCnt     <= '0;
    end else if (abortNow) begin
      inXfer     <= 1'b0;
      keyPtr     <= '0;
      keyBlocked <= 1'b0;
      bitCnt     <= '0;
    end else if (cycValid) begin
      if (inXfer) begin
        bitCnt <= bitCnt + 1'b1;
        if (xferLast) begin
          inXfer     <= 1'b0;
          keyPtr     <= '0;
          keyBlocked <= 1'b0;
          bitCnt     <= '0;
        end
      end else if (!cycWrite) begin
        keyPtr     <= '0;
        keyBlocked <= 1'b0;
      end else if (!keyBlocked) begin
        if (keyHit) begin
          if (keyLast) begin
            inXfer <= 1'b1;
            keyPtr <= '0;
            bitCnt <= '0;
          end else begin
            keyPtr <= keyPtr + 1'b1;
          end
        end else begin
          keyBlocked <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ksp_dp.sv
module ksp_dp
  import ksp_pkg::*;
#(
  parameter int  NREG = N_REG,
  parameter int  REGW = REG_W,
  localparam int XB   = NREG * REGW,
  localparam int XIDX = $clog2(XB),
  localparam int BW   = $clog2(REGW),
  localparam int RW   = XIDX - BW
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic            dqIn,
  input  logic [XB-1:0]   tkSnap,
  output logic            dqOut,
  output logic [NREG-1:0] tkWrEn,
  output logic [REGW-1:0] tkWrData
);
  logic [XB-1:0]   snapReg;
  logic [REGW-1:0] byteBuf;
  logic [NREG-1:0] regHit;
  logic [RW-1:0]   regIdx;
  logic [BW-1:0]   bitPos;
  logic            snapBit;

  assign regIdx  = stb.bitIdx[XIDX-1:BW];
  assign bitPos  = stb.bitIdx[BW-1:0];
  assign snapBit = snapReg[stb.bitIdx];
  assign dqOut   = stb.shiftRd && snapBit;

  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign regHit[r] = stb.commit && (regIdx == RW'(r));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapReg <= '0;
    end else if (stb.loadSnap) begin
      snapReg <= tkSnap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteBuf <= '0;
    end else if (stb.shiftWr) begin
      byteBuf[bitPos] <= dqIn;
    end else if (stb.shiftRd) begin
      byteBuf[bitPos] <= snapBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tkWrEn   <= '0;
      tkWrData <= '0;
    end else begin
      tkWrEn <= regHit;
      if (stb.commit) begin
        tkWrData <= {dqIn, byteBuf[REGW-2:0]};
      end
    end
  end
endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port
  import ksp_pkg::*;
#(
  parameter int              NREG = N_REG,
  parameter int              REGW = REG_W,
  parameter int              KEYW = KEY_BITS,
  parameter logic [KEYW-1:0] KEY  = UNLOCK_KEY,
  localparam int             XB   = NREG * REGW,
  localparam int             KPW  = $clog2(KEYW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cycValid,
  input  logic            cycWrite,
  input  logic            cycDq0,
  input  logic            rstPinN,
  input  logic            rstIgnore,
  input  logic [XB-1:0]   tkSnap,
  output logic            memGrant,
  output logic            dqOut,
  output logic            dqOutEn,
  output logic [NREG-1:0] tkWrEn,
  output logic [REGW-1:0] tkWrData
);
  strobe_t        stb;
  logic           inXfer;
  logic [KPW-1:0] keyPtr;
  logic           keyBlocked;
  logic           abortReq;

  assign abortReq = !rstPinN && !rstIgnore;

  ksp_ctrl #(.KEYW(KEYW), .KEY(KEY), .NREG(NREG), .REGW(REGW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .cycDq0(cycDq0), .abortReq(abortReq), .stb(stb), .inXfer(inXfer),
    .keyPtr(keyPtr), .keyBlocked(keyBlocked), .memGrant(memGrant),
    .dqOutEn(dqOutEn)
  );

  ksp_dp #(.NREG(NREG), .REGW(REGW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dqIn(cycDq0), .tkSnap(tkSnap),
    .dqOut(dqOut), .tkWrEn(tkWrEn), .tkWrData(tkWrData)
  );
endmodule

// File: rtl/ksp_checker.sv
module ksp_checker #(
  parameter int NREG = 8,
  parameter int KPW  = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            cycValid,
  input logic            cycWrite,
  input logic            rstPinN,
  input logic            rstIgnore,
  input logic            memGrant,
  input logic            dqOutEn,
  input logic [NREG-1:0] tkWrEn,
  input logic            inXfer,
  input logic [KPW-1:0]  keyPtr
);
  AST_COMMIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tkWrEn)); // R8
  AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|tkWrEn) |-> $past(cycValid && cycWrite && inXfer)); // R8
  AST_NO_GRANT_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    inXfer |-> !memGrant); // R9
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inXfer |-> !dqOutEn); // R3
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inXfer && cycValid) |-> memGrant); // R3
  AST_ABORT_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    (inXfer && !rstPinN && !rstIgnore) |=> !inXfer); // R10
  AST_READ_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    (!inXfer && cycValid && !cycWrite) |=> (keyPtr == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!inXfer && !cycValid) |=> $stable(keyPtr)); // R12
endmodule

bind keyed_serial_port ksp_checker #(.NREG(NREG), .KPW(KPW)) u_chk (
  .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
  .rstPinN(rstPinN), .rstIgnore(rstIgnore), .memGrant(memGrant),
  .dqOutEn(dqOutEn), .tkWrEn(tkWrEn), .inXfer(inXfer), .keyPtr(keyPtr)
);

// File: tb/sim_keyed_serial_port.sv
module sim_keyed_serial_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycValid = 1'b0, cycWrite = 1'b0, cycDq0 = 1'b0;
  logic        rstPinN = 1'b1, rstIgnore = 1'b0;
  logic [63:0] tkSnap = '0;
  logic        memGrant, dqOut, dqOutEn;
  logic [7:0]  tkWrEn, tkWrData;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit        mXfer = 0, mBlk = 0;
  int        mPtr = 0, mBit = 0;
  bit [63:0] mSnap = '0;
  bit [7:0]  mBuf = '0;
  bit        lastGrant, lastDqEn;

  always #2 clk = ~clk;

  keyed_serial_port u0 (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .cycDq0(cycDq0), .rstPinN(rstPinN), .rstIgnore(rstIgnore), .tkSnap(tkSnap),
    .memGrant(memGrant), .dqOut(dqOut), .dqOutEn(dqOutEn), .tkWrEn(tkWrEn),
    .tkWrData(tkWrData)
  );

  function automatic bit keyBit(int i);
    bit [7:0] kb [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    return kb[(i / 8) % 4][i % 8];
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit v, bit w, bit d, bit rp = 1, bit ri = 0);
    bit abort, eDqEn, eDq;
    bit [7:0] eWe, eWd;
    int pos;
    @(negedge clk);
    cycValid = v; cycWrite = w; cycDq0 = d; rstPinN = rp; rstIgnore = ri;
    tkSnap = {$urandom, $urandom};
    #1;
    abort = mXfer && !rp && !ri;
    eDqEn = v && !w && mXfer && !abort;
    eDq   = eDqEn ? mSnap[mBit] : 1'b0;
    lastGrant = memGrant; lastDqEn = dqOutEn;
    check(mXfer ? "R9 grant" : "R3 grant", memGrant, v && !mXfer);
    check(abort ? "R10 drive" : "R9 drive", dqOutEn, eDqEn);
    if (eDqEn) check("R6/R7 bit", dqOut, eDq);
    eWe = '0; eWd = '0;
    if (abort) begin
      mXfer = 0; mPtr = 0; mBlk = 0; mBit = 0;
    end else if (v) begin
      if (mXfer) begin
        pos = mBit % 8;
        mBuf[pos] = w ? d : mSnap[mBit];
        if (w && pos == 7) begin
          eWe = 8'(1 << (mBit / 8));
          eWd = mBuf;
        end
        mBit++;
        if (mBit == 64) begin mXfer = 0; mPtr = 0; mBlk = 0; mBit = 0; end
      end else if (!w) begin
        mPtr = 0; mBlk = 0;
      end else if (!mBlk) begin
        if (d == keyBit(mPtr)) begin
          if (mPtr == 63) begin mXfer = 1; mPtr = 0; mBit = 0; mSnap = tkSnap; end
          else mPtr++;
        end else mBlk = 1;
      end
    end
    @(posedge clk); #1;
    check(abort ? "R10 commit" : "R8 commit", tkWrEn, eWe);
    if (eWe != 0) check("R8 data", tkWrData, eWd);
    cycValid = 0;
  endtask

  task automatic sendKey(int from = 0, int upto = 64, bit gaps = 0);
    for (int i = from; i < upto; i++) begin
      if (gaps && ($urandom % 3 == 0)) cyc(0, 1, $urandom % 2); // R12 idle gap
      cyc(1, 1, keyBit(i));
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 commit", tkWrEn, 0);
    check("R1 drive", dqOutEn, 0);
    @(negedge clk); rstN = 1;
    cyc(1, 0, 0);
    check("R1 grant", lastGrant, 1);

    // full unlock, read-out of the captured image
    sendKey();
    cyc(1, 0, 0);
    check("R2 unlocked", lastGrant, 0);
    for (int i = 1; i < 64; i++) cyc(1, 0, 0);
    cyc(1, 0, 0);
    check("R7 back to memory", lastGrant, 1);

    // mismatch freezes recognition
    cyc(1, 0, 0);
    sendKey(0, 5); cyc(1, 1, !keyBit(5)); sendKey(6, 64);
    cyc(1, 0, 0);
    check("R4 no unlock", lastGrant, 1);
    sendKey();
    cyc(1, 1, 1);
    check("R4 rearmed unlock", lastGrant, 0);
    for (int i = 1; i < 64; i++) cyc(1, 1, $urandom % 2);

    // read mid-key restarts recognition
    cyc(1, 0, 0); sendKey(0, 20); cyc(1, 0, 0); sendKey(20, 64);
    cyc(1, 0, 0);
    check("R5 partial then read", lastGrant, 1);
    sendKey(0, 20); cyc(1, 0, 0); sendKey();
    cyc(1, 0, 0);
    check("R5 restart unlock", lastGrant, 0);
    for (int i = 1; i < 64; i++) cyc(1, ($urandom % 2) == 1, $urandom % 2);

    // abort mid transfer
    cyc(1, 0, 0); sendKey();
    for (int i = 0; i < 20; i++) cyc(1, 1, $urandom % 2);
    cyc(1, 1, 1, 0, 0);
    cyc(1, 1, 1);
    check("R10 memory after abort", lastGrant, 1);
    for (int i = 0; i < 70; i++) cyc(1, 1, $urandom % 2);
    cyc(1, 0, 0);

    // pin ignored
    sendKey();
    for (int i = 0; i < 64; i++) cyc(1, 1, $urandom % 2, 0, 1);
    cyc(1, 0, 0);
    check("R11 transfer completed", lastGrant, 1);

    // idle gaps during key and transfer
    sendKey(0, 64, 1);
    cyc(0, 0, 0);
    cyc(1, 0, 0);
    check("R12 unlock through gaps", lastGrant, 0);
    for (int i = 1; i < 64; i++) begin
      if ($urandom % 4 == 0) cyc(0, 1, 1);
      cyc(1, 1, $urandom % 2);
    end

    // constrained random rounds
    void'($urandom(32'd2024));
    for (int r = 0; r < 40; r++) begin
      cyc(1, 0, 0);
      sendKey(0, 64, 1);
      for (int i = 0; i < 64; i++) begin
        bit ri = ($urandom % 2) == 1;
        bit rp = ($urandom % 60) != 0;
        cyc(($urandom % 5) != 0, ($urandom % 2) == 1, $urandom % 2, rp, ri);
      end
      repeat (2) cyc(1, ($urandom % 2) == 1, $urandom % 2);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule